// File: doc/BRIEF.md
# Command Stream Word Parser

This block takes a stream of 32-bit command-buffer words and works out what each one is: either an opcode header or a data word that belongs to the most recent header. For each header it decodes the fields. It keeps count of how many trailing data words are still owed, and it holds a payload count that the two wide-format write opcodes draw on. Every accepted word produces exactly one event. A data word becomes a register-write event that carries the current class, the target register offset and the data. Gather, restart, lock and ID-setting headers are only reported as decoded events. The block does not fetch memory, take locks or apply IDs.

The input and output are both valid/ready streams. A word is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. The event it produces appears on the following cycle and stays unchanged on the port until `ev_ready` is seen high. The block can hold only one event at a time, so back-pressure passes straight through: `cmd_ready` is high when the output register is empty or is being drained in the same cycle. `buf_start` is a plain, synchronous control pin that marks the start of a new command buffer.

Top module: `cmd_word_parser`

## Requirements
- R1: `cmd_ready` equals (not `ev_valid`) or `ev_ready`. Each accepted word gives exactly one event, with `ev_valid` high on the next cycle. While `ev_valid` is high and `ev_ready` is low, every event field stays stable.
- R2: A header's opcode is word bits 31:28 and is echoed on `ev_op`; a data word echoes its owning header's opcode. Opcodes 13 and 15 give kind UNKNOWN (12) with `ev_data` equal to the word, offset 0, and no trailing words. Kind codes: WRITE=0, CLASS=1, BURST=2, GATHER=3, GATHER_ADDR=4, RESTART=5, STREAM=6, APPID=7, PAYLOAD=8, LOCK_TAKE=9, LOCK_DROP=10, EXT_UNKNOWN=11, UNKNOWN=12.
- R3: Opcode 0 sets the class to bits 15:6 and gives kind CLASS with the new class, offset = bits 27:16 and data = the popcount of the 6-bit mask in bits 5:0. That many WRITE words follow. Each goes to offset base + index of the next set mask bit, taken from the lowest bit up, under the new class.
- R4: Opcodes 1 (stepping) and 2 (fixed) give kind BURST with offset = bits 27:16 and data = count = bits 15:0. Then count WRITE words follow. With opcode 1 the offset rises by one per word; with opcode 2 it stays the same. A count of 0 means no words follow.
- R5: Opcode 3 gives kind BURST with offset = bits 27:16 and data = the popcount of the 16-bit mask in bits 15:0. Its WRITE words are placed at base + index of each set bit, lowest bit first.
- R6: Opcode 4 gives one WRITE event with offset = bits 27:16 and data = bits 15:0, zero-extended. No trailing words follow.
- R7: Opcode 6 gives kind GATHER with offset = bits 27:16 and data = bits 15:0 (insert bit 15, type bit 14, count bits 13:0), then one GATHER_ADDR word. Opcode 12 gives GATHER with offset 0 and data = bits 13:0, then two GATHER_ADDR words. A GATHER_ADDR event carries the raw word and offset 0.
- R8: Opcode 9 stores bits 15:0 as the payload and reports it as kind PAYLOAD. Opcodes 10 (stepping) and 11 (fixed) give kind BURST with offset = bits 21:0 and data = payload, followed by payload WRITE words. Offsets are 22-bit and wrap.
- R9: If opcode 10 or 11 arrives while the payload is invalid, it gives kind UNKNOWN with data = the word, and no trailing words.
- R10: Opcode 5 gives RESTART with data = word shifted left by 4 (truncated to 32 bits). Opcode 7 gives STREAM with data = bits 21:0. Opcode 8 gives APPID with data = bits 7:0.
- R11: Opcode 14 reads a sub-op from bits 27:24. Sub-op 0 gives LOCK_TAKE and sub-op 1 gives LOCK_DROP, each with data = bits 7:0. Any other sub-op gives EXT_UNKNOWN with data = the word.
- R12: `buf_start` high in a cycle clears the owed-word count and invalidates the payload. A word accepted in that same cycle is decoded as a header with the payload invalid. The class is not affected.
- R13: After reset `ev_valid` is 0, `cmd_ready` is 1, the class is 0, the payload is invalid and the next word is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_start | input | 1 | Start-of-buffer pulse |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted when high with valid |
| cmd_word | input | 32 | Command-buffer word |
| ev_valid | output | 1 | Event valid |
| ev_ready | input | 1 | Downstream accepts event |
| ev_kind | output | 4 | Event kind code |
| ev_op | output | 4 | Opcode of header (or owning header) |
| ev_class | output | 10 | Current target class |
| ev_offset | output | 22 | Register offset |
| ev_data | output | 32 | Event data |

## Verification
A wrong owed-word count or a wrong payload state appears at the output as soon as the next word is accepted. That word gets the wrong classification: a data word is reported as a header event, or a header is emitted as a WRITE. The error is seen one cycle after acceptance. A wrong offset or mask register shows up on the next data word of the burst as a wrong `ev_offset`. A fault in the class register shows up on every later WRITE. The bench model therefore compares every event field each time an event leaves the block, and it checks the handshake pins on every clock. Stall periods are mixed in so that a stalled event that changes is caught.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 4;
  localparam int CLS_W  = 10;
  localparam int OFF_W  = 22;
  localparam int CNT_W  = 16;
  localparam int MSK_W  = 16;
  localparam int IDX_W  = $clog2(MSK_W);

  localparam logic [OP_W-1:0] OP_SETCL  = 4'd0;
  localparam logic [OP_W-1:0] OP_INCR   = 4'd1;
  localparam logic [OP_W-1:0] OP_NONINC = 4'd2;
  localparam logic [OP_W-1:0] OP_MASK   = 4'd3;
  localparam logic [OP_W-1:0] OP_IMM    = 4'd4;
  localparam logic [OP_W-1:0] OP_RESTRT = 4'd5;
  localparam logic [OP_W-1:0] OP_GATH   = 4'd6;
  localparam logic [OP_W-1:0] OP_STRM   = 4'd7;
  localparam logic [OP_W-1:0] OP_APPID  = 4'd8;
  localparam logic [OP_W-1:0] OP_PYLD   = 4'd9;
  localparam logic [OP_W-1:0] OP_INCW   = 4'd10;
  localparam logic [OP_W-1:0] OP_NONW   = 4'd11;
  localparam logic [OP_W-1:0] OP_GATHW  = 4'd12;
  localparam logic [OP_W-1:0] OP_EXT    = 4'd14;

  typedef enum logic [3:0] {
    K_WRITE = 4'd0, K_CLASS = 4'd1, K_BURST = 4'd2, K_GATHER = 4'd3,
    K_GADDR = 4'd4, K_RESTART = 4'd5, K_STREAM = 4'd6, K_APPID = 4'd7,
    K_PAYLOAD = 4'd8, K_LOCK_TAKE = 4'd9, K_LOCK_DROP = 4'd10,
    K_EXT_UNK = 4'd11, K_UNKNOWN = 4'd12
  } ev_kind_e;

  typedef enum logic [1:0] {M_STEP, M_FIXED, M_MASKED, M_ADDR} dmode_e;

  typedef struct packed {
    ev_kind_e              kind;
    logic [OP_W-1:0]       op;
    logic [CLS_W-1:0]      cls;
    logic [OFF_W-1:0]      off;
    logic [WORD_W-1:0]     data;
  } ev_t;

  function automatic logic [CNT_W-1:0] bit_total(input logic [MSK_W-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < MSK_W; i++) n = n + CNT_W'(m[i]);
    return n;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_set(input logic [MSK_W-1:0] m);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = MSK_W - 1; i >= 0; i--) if (m[i]) idx = IDX_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/cwp_header_dec.sv
module cwp_header_dec
  import cwp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [CLS_W-1:0]  cur_cls,
  input  logic              pay_ok,
  input  logic [CNT_W-1:0]  pay_val,
  output ev_t               ev,
  output logic [CNT_W-1:0]  rem_n,
  output dmode_e            mode_n,
  output logic [OFF_W-1:0]  base_n,
  output logic [MSK_W-1:0]  mask_n,
  output logic              cls_we,
  output logic              pay_we
);
  localparam int SHORT_OFF = 12;

  logic [OP_W-1:0]      op;
  logic [OFF_W-1:0]     off_short;
  logic [OFF_W-1:0]     off_wide;
  logic [3:0]           sub;
  logic [MSK_W-1:0]     cl_mask;
  logic [MSK_W-1:0]     wr_mask;

  assign op        = word[WORD_W-1 -: OP_W];
  assign off_short = OFF_W'(word[16 +: SHORT_OFF]);
  assign off_wide  = word[OFF_W-1:0];
  assign sub       = word[27:24];
  assign cl_mask   = MSK_W'(word[5:0]);
  assign wr_mask   = word[MSK_W-1:0];

  always_comb begin
    ev      = '0;
    ev.kind = K_UNKNOWN;
    ev.op   = op;
    ev.cls  = cur_cls;
    ev.data = word;
    rem_n   = '0;
    mode_n  = M_FIXED;
    base_n  = '0;
    mask_n  = '0;
    cls_we  = 1'b0;
    pay_we  = 1'b0;
    case (op)
      OP_SETCL: begin
        cls_we  = 1'b1;
        ev.kind = K_CLASS;
        ev.cls  = word[6 +: CLS_W];
        ev.off  = off_short;
        mask_n  = cl_mask;
        rem_n   = bit_total(cl_mask);
        ev.data = WORD_W'(bit_total(cl_mask));
        mode_n  = M_MASKED;
        base_n  = off_short;
      end
      OP_INCR, OP_NONINC: begin
        ev.kind = K_BURST;
        ev.off  = off_short;
        rem_n   = word[CNT_W-1:0];
        ev.data = WORD_W'(word[CNT_W-1:0]);
        mode_n  = (op == OP_INCR) ? M_STEP : M_FIXED;
        base_n  = off_short;
      end
      OP_MASK: begin
        ev.kind = K_BURST;
        ev.off  = off_short;
        mask_n  = wr_mask;
        rem_n   = bit_total(wr_mask);
        ev.data = WORD_W'(bit_total(wr_mask));
        mode_n  = M_MASKED;
        base_n  = off_short;
      end
      OP_IMM: begin
        ev.kind = K_WRITE;
        ev.off  = off_short;
        ev.data = WORD_W'(word[15:0]);
      end
      OP_RESTRT: begin
        ev.kind = K_RESTART;
        ev.data = word << 4;
      end
      OP_GATH: begin
        ev.kind = K_GATHER;
        ev.off  = off_short;
        ev.data = WORD_W'(word[15:0]);
        rem_n   = CNT_W'(1);
        mode_n  = M_ADDR;
      end
      OP_GATHW: begin
        ev.kind = K_GATHER;
        ev.data = WORD_W'(word[13:0]);
        rem_n   = CNT_W'(2);
        mode_n  = M_ADDR;
      end
      OP_STRM: begin
        ev.kind = K_STREAM;
        ev.data = WORD_W'(word[21:0]);
      end
      OP_APPID: begin
        ev.kind = K_APPID;
        ev.data = WORD_W'(word[7:0]);
      end
      OP_PYLD: begin
        pay_we  = 1'b1;
        ev.kind = K_PAYLOAD;
        ev.data = WORD_W'(word[CNT_W-1:0]);
      end
      OP_INCW, OP_NONW: begin
        if (pay_ok) begin
          ev.kind = K_BURST;
          ev.off  = off_wide;
          ev.data = WORD_W'(pay_val);
          rem_n   = pay_val;
          mode_n  = (op == OP_INCW) ? M_STEP : M_FIXED;
          base_n  = off_wide;
        end
      end
      OP_EXT: begin
        if (sub == 4'd0) begin
          ev.kind = K_LOCK_TAKE;
          ev.data = WORD_W'(word[7:0]);
        end else if (sub == 4'd1) begin
          ev.kind = K_LOCK_DROP;
          ev.data = WORD_W'(word[7:0]);
        end else begin
          ev.kind = K_EXT_UNK;
        end
      end
      default: ev.kind = K_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/cwp_data_step.sv
module cwp_data_step
  import cwp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  dmode_e            mode,
  input  logic [OP_W-1:0]   op,
  input  logic [CLS_W-1:0]  cls,
  input  logic [OFF_W-1:0]  off,
  input  logic [MSK_W-1:0]  mask,
  output ev_t               ev,
  output logic [OFF_W-1:0]  off_n,
  output logic [MSK_W-1:0]  mask_n
);
  logic [IDX_W-1:0] idx;
  assign idx = lowest_set(mask);

  always_comb begin
    ev      = '0;
    ev.kind = K_WRITE;
    ev.op   = op;
    ev.cls  = cls;
    ev.data = word;
    ev.off  = off;
    off_n   = off;
    mask_n  = mask;
    case (mode)
      M_STEP:   off_n = off + OFF_W'(1);
      M_FIXED:  off_n = off;
      M_MASKED: begin
        ev.off      = off + OFF_W'(idx);
        mask_n[idx] = 1'b0;
      end
      default: begin
        ev.kind = K_GADDR;
        ev.off  = '0;
      end
    endcase
  end
endmodule

// File: rtl/cwp_ev_reg.sv
module cwp_ev_reg
  import cwp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  ev_t  ev_in,
  output logic out_valid,
  input  logic out_ready,
  output ev_t  ev_out
);
  logic vld_q;
  ev_t  ev_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign ev_out    = ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ev_q  <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) ev_q <= ev_in;
    end
  end
endmodule

// File: rtl/cmd_word_parser.sv
module cmd_word_parser
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_start,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_word,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [3:0]        ev_kind,
  output logic [3:0]        ev_op,
  output logic [9:0]        ev_class,
  output logic [21:0]       ev_offset,
  output logic [31:0]       ev_data
);
  logic [CNT_W-1:0] rem_q;
  dmode_e           mode_q;
  logic [OFF_W-1:0] off_q;
  logic [MSK_W-1:0] mask_q;
  logic [OP_W-1:0]  op_q;
  logic [CLS_W-1:0] cls_q;
  logic             pay_ok_q;
  logic [CNT_W-1:0] pay_q;

  logic             take;
  logic             hdr;
  logic             pay_ok_eff;
  ev_t              hdr_ev, dat_ev, sel_ev, out_ev;
  logic [CNT_W-1:0] h_rem;
  dmode_e           h_mode;
  logic [OFF_W-1:0] h_base, d_off;
  logic [MSK_W-1:0] h_mask, d_mask;
  logic             h_cls_we, h_pay_we;

  assign take       = cmd_valid && cmd_ready;
  assign hdr        = buf_start || (rem_q == '0);
  assign pay_ok_eff = pay_ok_q && !buf_start;
  assign sel_ev     = hdr ? hdr_ev : dat_ev;

  cwp_header_dec dec_i (
    .word(cmd_word), .cur_cls(cls_q), .pay_ok(pay_ok_eff), .pay_val(pay_q),
    .ev(hdr_ev), .rem_n(h_rem), .mode_n(h_mode), .base_n(h_base),
    .mask_n(h_mask), .cls_we(h_cls_we), .pay_we(h_pay_we)
  );

  cwp_data_step step_i (
    .word(cmd_word), .mode(mode_q), .op(op_q), .cls(cls_q), .off(off_q),
    .mask(mask_q), .ev(dat_ev), .off_n(d_off), .mask_n(d_mask)
  );

  cwp_ev_reg oreg_i (
    .clk(clk), .rst_n(rst_n), .in_valid(cmd_valid), .in_ready(cmd_ready),
    .ev_in(sel_ev), .out_valid(ev_valid), .out_ready(ev_ready), .ev_out(out_ev)
  );

  assign ev_kind   = out_ev.kind;
  assign ev_op     = out_ev.op;
  assign ev_class  = out_ev.cls;
  assign ev_offset = out_ev.off;
  assign ev_data   = out_ev.data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      mode_q   <= M_FIXED;
      off_q    <= '0;
      mask_q   <= '0;
      op_q     <= '0;
      cls_q    <= '0;
      pay_ok_q <= 1'b0;
      pay_q    <= '0;
    end else begin
      if (buf_start) begin
        rem_q    <= '0;
        pay_ok_q <= 1'b0;
      end
      if (take) begin
        if (hdr) begin
          rem_q  <= h_rem;
          mode_q <= h_mode;
          off_q  <= h_base;
          mask_q <= h_mask;
          op_q   <= hdr_ev.op;
          if (h_cls_we) cls_q <= hdr_ev.cls;
          if (h_pay_we) begin
            pay_ok_q <= 1'b1;
            pay_q    <= cmd_word[CNT_W-1:0];
          end
        end else begin
          rem_q  <= rem_q - CNT_W'(1);
          off_q  <= d_off;
          mask_q <= d_mask;
        end
      end
    end
  end
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker
  import cwp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             buf_start,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [3:0]       ev_kind,
  input logic [3:0]       ev_op,
  input logic [21:0]      ev_offset,
  input logic [31:0]      ev_data,
  input logic [CNT_W-1:0] rem
);
  a_r1_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_data) && $stable(ev_kind)
      && $stable(ev_offset) && $stable(ev_op));

  a_r1_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> ev_valid);

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || !cmd_ready) && (!ev_valid || ev_ready) |=> !ev_valid);

  a_r12_start_is_header: assert property (@(posedge clk) disable iff (!rst_n)
    buf_start && cmd_valid && cmd_ready |=>
      (ev_kind != K_GADDR) && (ev_kind != K_WRITE || ev_op == OP_IMM));

  a_r7_addr_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_kind == K_GADDR |-> (ev_op == OP_GATH || ev_op == OP_GATHW));

  a_r2_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_kind <= K_UNKNOWN);

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !buf_start && rem != '0 |=> rem == $past(rem) - CNT_W'(1));
endmodule

bind cmd_word_parser cwp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .buf_start(buf_start), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_kind(ev_kind), .ev_op(ev_op), .ev_offset(ev_offset), .ev_data(ev_data),
  .rem(rem_q)
);

// File: tb/cmd_word_parser_tb_top.sv
module cmd_word_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_start = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic        ev_valid;
  logic        ev_ready = 1'b0;
  logic [3:0]  ev_kind, ev_op;
  logic [9:0]  ev_class;
  logic [21:0] ev_offset;
  logic [31:0] ev_data;

  always #10 clk = ~clk;

  cmd_word_parser dut_i (
    .clk(clk), .rst_n(rst_n), .buf_start(buf_start), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_word(cmd_word), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_op(ev_op), .ev_class(ev_class),
    .ev_offset(ev_offset), .ev_data(ev_data)
  );

  typedef struct { int kind; int op; int cls; int off; bit [31:0] data; string tag; } exp_t;
  typedef struct { bit sob; bit [31:0] w; } item_t;

  exp_t  eq[$];
  item_t stim[$];
  int total = 0, bad = 0;

  // reference state
  int m_rem = 0, m_mode = 0, m_off = 0, m_op = 0, m_cls = 0, m_pay = -1;
  bit [15:0] m_mask;
  string m_tag = "R2";

  function automatic bit [31:0] hw(int op, bit [27:0] rest);
    return {op[3:0], rest};
  endfunction

  task automatic add(bit sob, bit [31:0] w);
    item_t it;
    it.sob = sob; it.w = w;
    stim.push_back(it);
  endtask

  task automatic expect_ev(int kind, int op, int cls, int off, bit [31:0] data, string tag);
    exp_t e;
    e.kind = kind; e.op = op; e.cls = cls; e.off = off; e.data = data; e.tag = tag;
    eq.push_back(e);
  endtask

  task automatic model_word(bit [31:0] w);
    int op, o12, sub, idx;
    op  = int'(w[31:28]);
    o12 = int'(w[27:16]);
    if (m_rem > 0) begin
      m_rem--;
      if (m_mode == 3) expect_ev(4, m_op, m_cls, 0, w, "R7");
      else if (m_mode == 2) begin
        idx = 0;
        for (int b = 15; b >= 0; b--) if (m_mask[b]) idx = b;
        m_mask[idx] = 1'b0;
        expect_ev(0, m_op, m_cls, (m_off + idx) & 32'h3FFFFF, w, m_tag);
      end else begin
        expect_ev(0, m_op, m_cls, m_off, w, m_tag);
        if (m_mode == 0) m_off = (m_off + 1) & 32'h3FFFFF;
      end
      return;
    end
    m_op = op;
    case (op)
      0: begin
        m_cls = int'(w[15:6]); m_mask = {10'b0, w[5:0]}; m_rem = $countones(w[5:0]);
        m_mode = 2; m_off = o12; m_tag = "R3";
        expect_ev(1, op, m_cls, o12, m_rem, "R3");
      end
      1, 2: begin
        m_rem = int'(w[15:0]); m_mode = (op == 1) ? 0 : 1; m_off = o12; m_tag = "R4";
        expect_ev(2, op, m_cls, o12, m_rem, "R4");
      end
      3: begin
        m_mask = w[15:0]; m_rem = $countones(w[15:0]); m_mode = 2; m_off = o12; m_tag = "R5";
        expect_ev(2, op, m_cls, o12, m_rem, "R5");
      end
      4: expect_ev(0, op, m_cls, o12, {16'b0, w[15:0]}, "R6");
      5: expect_ev(5, op, m_cls, 0, {w[27:0], 4'b0}, "R10");
      6: begin m_rem = 1; m_mode = 3; expect_ev(3, op, m_cls, o12, {16'b0, w[15:0]}, "R7"); end
      12: begin m_rem = 2; m_mode = 3; expect_ev(3, op, m_cls, 0, {18'b0, w[13:0]}, "R7"); end
      7: expect_ev(6, op, m_cls, 0, {10'b0, w[21:0]}, "R10");
      8: expect_ev(7, op, m_cls, 0, {24'b0, w[7:0]}, "R10");
      9: begin m_pay = int'(w[15:0]); expect_ev(8, op, m_cls, 0, {16'b0, w[15:0]}, "R8"); end
      10, 11: begin
        if (m_pay < 0) expect_ev(12, op, m_cls, 0, w, "R9");
        else begin
          m_rem = m_pay; m_mode = (op == 10) ? 0 : 1; m_off = int'(w[21:0]); m_tag = "R8";
          expect_ev(2, op, m_cls, m_off, m_pay, "R8");
        end
      end
      14: begin
        sub = int'(w[27:24]);
        if (sub == 0) expect_ev(9, op, m_cls, 0, {24'b0, w[7:0]}, "R11");
        else if (sub == 1) expect_ev(10, op, m_cls, 0, {24'b0, w[7:0]}, "R11");
        else expect_ev(11, op, m_cls, 0, w, "R11");
      end
      default: expect_ev(12, op, m_cls, 0, w, "R2");
    endcase
  endtask

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic gen_random(int n);
    for (int i = 0; i < n; i++) begin
      int pick, cnt;
      bit sob;
      pick = $urandom_range(0, 15);
      sob  = ($urandom_range(0, 19) == 0);
      case (pick)
        0: begin
          add(sob, hw(0, {12'($urandom), 10'($urandom), 6'($urandom)}));
          cnt = 0;
          begin
            bit [31:0] hdr; hdr = stim[$].w; cnt = $countones(hdr[5:0]);
          end
          for (int k = 0; k < cnt; k++) add(0, $urandom);
        end
        1, 2: begin
          cnt = $urandom_range(0, 4);
          add(sob, hw(pick, {12'($urandom), 16'(cnt)}));
          for (int k = 0; k < cnt; k++) add(0, $urandom);
        end
        3: begin
          bit [15:0] mk; mk = 16'($urandom) & 16'($urandom) & 16'($urandom);
          add(sob, hw(3, {12'($urandom), mk}));
          for (int k = 0; k < $countones(mk); k++) add(0, $urandom);
        end
        6: begin add(sob, hw(6, 28'($urandom))); add(0, $urandom); end
        12: begin add(sob, hw(12, 28'($urandom))); add(0, $urandom); add(0, $urandom); end
        10, 11: begin
          cnt = $urandom_range(0, 3);
          add(sob, hw(9, {12'($urandom), 16'(cnt)}));
          add(0, hw(pick, 28'($urandom)));
          for (int k = 0; k < cnt; k++) add(0, $urandom);
        end
        default: add(sob, hw(pick, 28'($urandom)));
      endcase
    end
  endtask

  initial begin
    int cyc = 0;
    bit acc_last = 0;
    bit exp_rdy, acc, pop;
    bit wd_fired = 0;
    bit busy_ready = 0;

    // directed program
    add(0, hw(10, 28'h0000123));                 // R13: payload invalid after reset -> R9
    add(1, hw(0, {12'h010, 10'h12A, 6'b101001})); // R3 three writes
    add(0, 32'hA0000001); add(0, 32'hA0000002); add(0, 32'hA0000003);
    add(0, hw(0, {12'h7FF, 10'h055, 6'b0}));      // R3 class only
    add(0, hw(1, {12'h020, 16'd3}));              // R4 stepping
    add(0, 32'h11); add(0, 32'h22); add(0, 32'h33);
    add(0, hw(2, {12'h030, 16'd2}));              // R4 fixed
    add(0, 32'h44); add(0, 32'h55);
    add(0, hw(1, {12'h0AB, 16'd0}));              // R4 zero count
    add(0, hw(3, {12'h040, 16'h8001}));           // R5
    add(0, 32'h66); add(0, 32'h77);
    add(0, hw(4, {12'h050, 16'hBEEF}));           // R6
    add(0, hw(6, {12'h060, 2'b10, 14'h0123}));    // R7
    add(0, 32'hDEAD0000);
    add(0, hw(12, {14'h1555, 14'h3FFF}));         // R7 wide
    add(0, 32'hCAFE0001); add(0, 32'hCAFE0002);
    add(0, hw(9, {12'h000, 16'd3}));              // R8
    add(0, hw(10, {6'h0, 22'h3FFFFE}));
    add(0, 32'h1); add(0, 32'h2); add(0, 32'h3);
    add(0, hw(11, {6'h3F, 22'h123456}));
    add(0, 32'h4); add(0, 32'h5); add(0, 32'h6);
    add(0, hw(9, 28'h0)); add(0, hw(10, 28'h0000777)); // R8 zero payload
    add(0, 32'h5ABCDEF1);                         // R10 restart
    add(0, hw(7, 28'hFFFFFFF)); add(0, hw(8, 28'h12345AB));
    add(0, hw(14, {4'd0, 16'h0, 8'h07}));         // R11
    add(0, hw(14, {4'd1, 16'h0, 8'hFF}));
    add(0, hw(14, {4'd5, 16'h0, 8'h01}));
    add(0, 32'hF0000042); add(0, 32'hD0000042);   // R2
    add(0, hw(1, {12'h100, 16'd5})); add(0, 32'h7); add(0, 32'h8);
    add(1, hw(11, 28'h0000001));                  // R12: cut burst, payload invalid
    add(0, hw(4, {12'h011, 16'h0022}));
    gen_random(300);

    repeat (3) @(negedge clk);
    check(ev_valid == 1'b0, "R13", "ev_valid in reset", ev_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ev_valid == 1'b0 && cmd_ready == 1'b1, "R13", "idle after reset",
          {ev_valid, cmd_ready}, 2'b01);

    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin wd_fired = 1; break; end
      // compare outputs against expectation for the last edge
      check(ev_valid == (eq.size() > 0), "R1", "ev_valid", ev_valid, eq.size() > 0);
      if (ev_valid && eq.size() > 0) begin
        exp_t e; e = eq[0];
        check(int'(ev_kind) == e.kind && int'(ev_op) == e.op && int'(ev_class) == e.cls
              && int'(ev_offset) == e.off && ev_data == e.data, e.tag,
              "event kind/op/class/offset/data",
              {ev_kind, ev_op, ev_class, ev_offset, ev_data},
              {e.kind[3:0], e.op[3:0], e.cls[9:0], e.off[21:0], e.data});
      end
      if (acc_last) void'(stim.pop_front());
      if (stim.size() == 0 && eq.size() == 0 && !(cmd_valid && !acc_last)) break;
      // new inputs
      if (!(cmd_valid && !acc_last)) begin
        if (stim.size() > 0 && $urandom_range(0, 9) < 7) begin
          cmd_valid = 1'b1; cmd_word = stim[0].w; buf_start = stim[0].sob;
        end else begin
          cmd_valid = 1'b0; buf_start = 1'b0; cmd_word = $urandom;
        end
      end
      if (cyc % 400 == 0) busy_ready = ~busy_ready;
      ev_ready = busy_ready ? 1'b1 : ($urandom_range(0, 9) < 6);
      #1;
      exp_rdy = (eq.size() == 0) || ev_ready;
      check(cmd_ready == exp_rdy, "R1", "cmd_ready", cmd_ready, exp_rdy);
      acc = cmd_valid && exp_rdy;
      pop = (eq.size() > 0) && ev_ready;
      if (buf_start) begin m_rem = 0; m_pay = -1; end
      if (pop) void'(eq.pop_front());
      if (acc) model_word(cmd_word);
      acc_last = acc;
    end
    if (wd_fired) begin
      bad++; total++;
      $display("FAIL R1 watchdog: actual=hung expected=drained");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule